// File: doc/BRIEF.md
# Dual-Phase Receive Character Clock Generator

This block runs on the serial bit clock of a receiver. From a stream of aligned 10-bit characters it makes two receive byte clocks. Each clock runs at half the character rate, and the two are in antiphase. Each character goes to the clock that should register it. The two clocks rise in turn, so a downstream protocol engine registers even characters on one clock and odd characters on the other. A character that carries a comma is steered onto the second clock, so that it becomes the first character of a four-character word.

The generator never makes a half-period shorter than one character time. A character boundary that arrives too early, for example just after the word aligner has moved the boundary, is dropped, and the current level is held longer. When the receiver reports that it is not locked, the clocks are driven from a reference-derived tick instead. Each half-period then lasts two character times, so the clocks run at half their nominal frequency.

A realign request from the word aligner does not act at once. It waits for the next boundary at which the second clock is due to rise. From there the first clock stays high until a comma arrives, and that comma is registered on the second clock. A hunt that finds no comma gives up after a bounded number of characters.

Top module: `rxclk_dual_phase`

## Requirements
- R1: In reset and immediately after it, `rbc0` is 0, `rbc1` is 1, both rise strobes are 0, both character outputs are 0, and the first clock due to rise is `rbc0`.
- R2: `rbc1` is always the inverse of `rbc0`, and successive clock edges alternate between a rise of `rbc0` and a rise of `rbc1`.
- R3: In locked mode, an accepted character strobe makes the due clock rise on the same clock edge that samples the strobe. The matching rise strobe pulses for one cycle, and that clock's character output loads `char_in`. A character output changes only when its clock rises.
- R4: Over a steady locked stream, characters go to `rbc0` and `rbc1` in turn, each clock receiving every second character.
- R5: A character strobe that arrives fewer than HALF (10) bit clocks after the last clock edge is ignored: there is no edge and both character outputs keep their values. No half-period of either clock is ever shorter than HALF bit clocks.
- R6: While `lock_ok` is low, character strobes are ignored and no character output changes. A clock edge occurs only on a `ref_tick` at least 2*HALF (20) bit clocks after the last edge, so with ticks every HALF clocks each half-period is 2*HALF.
- R7: A realign request is held until the next accepted strobe at which `rbc1` is due. A strobe at which `rbc0` is due is served normally. From the `rbc1` boundary on, non-comma strobes are discarded and `rbc0` stays high, until a comma character arrives. That comma makes `rbc1` rise and is loaded into `rx_ph1`.
- R8: A character is a comma when `char_in[6:0]` equals 7'b1111100, that is bits 0 and 1 are 0 and bits 2 to 6 are 1, bit 0 being the first serial bit. Bits 9 to 7 are ignored. Any other value, such as one with bit 0 set, is not a comma.
- R9: After HOLD_MAX (4) discarded strobes in one hunt, the next accepted strobe makes `rbc1` rise with its character even when it is not a comma, and the hunt ends.
- R10: Dropping `lock_ok` cancels a pending realign request, including one raised while `lock_ok` is low. After lock returns, characters at `rbc1` boundaries are served normally.
- R11: On a change from locked to reference mode, the first reference-driven edge still needs 2*HALF bit clocks since the last edge. A tick that comes sooner is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| char_stb | input | 1 | Character boundary strobe from the word aligner |
| char_in | input | CHAR_W (10) | Aligned character, bit 0 received first |
| realign_req | input | 1 | One-cycle request from the aligner to put the next comma on `rbc1` |
| lock_ok | input | 1 | Receiver holds valid data lock |
| ref_tick | input | 1 | Character-rate tick derived from the reference clock |
| rbc0 | output | 1 | Receive byte clock, phase 0 (characters 1 and 3 of a word) |
| rbc1 | output | 1 | Receive byte clock, phase 1 (characters 0 and 2 of a word) |
| rise0 | output | 1 | One-cycle pulse in the cycle `rbc0` has just risen |
| rise1 | output | 1 | One-cycle pulse in the cycle `rbc1` has just risen |
| rx_ph0 | output | CHAR_W (10) | Character registered on `rbc0` |
| rx_ph1 | output | CHAR_W (10) | Character registered on `rbc1` |

## Verification
Every output is registered once after the inputs. A strobe or tick sampled at a rising edge therefore shows its clock edge, rise pulse and character at that same edge, and the result stays valid for one cycle. The bench drives inputs at falling edges and reads results just after the next falling edge, which lies inside that one-cycle window. Stretch and fallback behaviour is judged by half-period lengths that a falling-edge monitor counts in whole bit clocks. This gives exact expected values: 10 for normal operation, 20 in reference mode and for a one-character stretch, and 50 for a timed-out hunt.

// File: rtl/rxclk_pkg.sv
package rxclk_pkg;

  // Command from the phase controller to the two output lanes.
  typedef struct packed {
    logic fire;    // one clock edge happens this cycle
    logic to_ph1;  // 1: rbc1 rises, 0: rbc0 rises
    logic load;    // the rising lane registers char_in
  } edge_cmd_t;

  localparam int NUM_LANES = 2;

endpackage

// File: rtl/rxclk_gap_timer.sv
// Counts bit clocks since the last output edge and says whether a new edge
// may be placed without shortening a half-period.
module rxclk_gap_timer #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_fire,
  output logic half_ok,
  output logic full_ok
);
  localparam int CW = $clog2(2 * HALF + 1);
  localparam logic [CW-1:0] SAT     = CW'(2 * HALF);
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(2 * HALF - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    if (edge_fire) begin
      cnt_n = '0;
    end else if (cnt_q == SAT) begin
      cnt_n = cnt_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign half_ok = (cnt_q >= HALF_M1);
  assign full_ok = (cnt_q >= FULL_M1);

endmodule

// File: rtl/rxclk_comma_detect.sv
// Matches the positive-disparity comma in the first bits of a character.
module rxclk_comma_detect #(
  parameter int              PAT_W = 7,
  parameter logic [PAT_W-1:0] PAT  = 7'b1111100
) (
  input  logic [PAT_W-1:0] head,
  output logic             hit
);
  logic [PAT_W-1:0] bit_eq;

  for (genvar g = 0; g < PAT_W; g++) begin : g_cmp
    assign bit_eq[g] = (head[g] == PAT[g]);
  end

  assign hit = &bit_eq;

endmodule

// File: rtl/rxclk_phase_ctrl.sv
// Decides when an edge happens, which lane rises and whether it loads data.
module rxclk_phase_ctrl
  import rxclk_pkg::*;
#(
  parameter int HOLD_MAX = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      char_stb,
  input  logic      ref_tick,
  input  logic      lock_ok,
  input  logic      realign_req,
  input  logic      is_comma,
  input  logic      half_ok,
  input  logic      full_ok,
  output edge_cmd_t cmd
);
  localparam int HW = $clog2(HOLD_MAX + 1);
  localparam logic [HW-1:0] HOLD_LIM = HW'(HOLD_MAX);

  logic          due_ph1_q;
  logic          due_ph1_n;
  logic          pend_q;
  logic          pend_n;
  logic [HW-1:0] hunt_q;
  logic [HW-1:0] hunt_n;
  logic          pend_now;
  logic          hunting;
  logic          take;

  always_comb begin
    cmd      = '0;
    pend_n   = pend_q;
    hunt_n   = hunt_q;
    pend_now = pend_q | realign_req;
    hunting  = due_ph1_q & pend_now;
    take     = 1'b0;

    if (!lock_ok) begin
      // Reference fallback: slow clocks, no data, no pending realign.
      pend_n = 1'b0;
      hunt_n = '0;
      if (ref_tick && full_ok) begin
        cmd.fire = 1'b1;
      end
    end else begin
      pend_n = pend_now;
      if (char_stb && half_ok) begin
        if (hunting && !is_comma && (hunt_q != HOLD_LIM)) begin
          // Stretch: drop this character, keep the current level.
          hunt_n = hunt_q + 1'b1;
        end else begin
          take = 1'b1;
        end
      end
      if (take) begin
        cmd.fire = 1'b1;
        cmd.load = 1'b1;
        if (due_ph1_q) begin
          pend_n = 1'b0;
          hunt_n = '0;
        end
      end
    end

    cmd.to_ph1 = due_ph1_q;
    due_ph1_n  = cmd.fire ? ~due_ph1_q : due_ph1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      due_ph1_q <= 1'b0;
      pend_q    <= 1'b0;
      hunt_q    <= '0;
    end else begin
      due_ph1_q <= due_ph1_n;
      pend_q    <= pend_n;
      hunt_q    <= hunt_n;
    end
  end

endmodule

// File: rtl/rxclk_lane_out.sv
// One output clock lane: level, rise pulse and registered character.
module rxclk_lane_out #(
  parameter int   CHAR_W = 10,
  parameter logic IS_PH1 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              to_ph1,
  input  logic              load,
  input  logic [CHAR_W-1:0] char_in,
  output logic              level,
  output logic              rise,
  output logic [CHAR_W-1:0] data
);
  logic              mine;
  logic              level_n;
  logic              rise_n;
  logic              data_en;
  logic [CHAR_W-1:0] data_n;

  assign mine    = (to_ph1 == IS_PH1);
  assign rise_n  = fire & mine;
  assign data_en = rise_n & load;

  always_comb begin
    level_n = level;
    if (fire) begin
      level_n = mine;
    end
    data_n = data_en ? char_in : data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= IS_PH1;
      rise  <= 1'b0;
      data  <= '0;
    end else begin
      level <= level_n;
      rise  <= rise_n;
      data  <= data_n;
    end
  end

endmodule

// File: rtl/rxclk_dual_phase.sv
module rxclk_dual_phase
  import rxclk_pkg::*;
#(
  parameter int CHAR_W   = 10,
  parameter int HALF     = 10,
  parameter int HOLD_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_stb,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              realign_req,
  input  logic              lock_ok,
  input  logic              ref_tick,
  output logic              rbc0,
  output logic              rbc1,
  output logic              rise0,
  output logic              rise1,
  output logic [CHAR_W-1:0] rx_ph0,
  output logic [CHAR_W-1:0] rx_ph1
);
  localparam int COMMA_W = 7;

  edge_cmd_t         cmd;
  logic              half_ok;
  logic              full_ok;
  logic              is_comma;
  logic [NUM_LANES-1:0] lane_level;
  logic [NUM_LANES-1:0] lane_rise;
  logic [CHAR_W-1:0] lane_data [NUM_LANES];

  rxclk_gap_timer #(.HALF(HALF)) i_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_fire(cmd.fire),
    .half_ok  (half_ok),
    .full_ok  (full_ok)
  );

  rxclk_comma_detect #(.PAT_W(COMMA_W), .PAT(7'b1111100)) i_comma (
    .head(char_in[COMMA_W-1:0]),
    .hit (is_comma)
  );

  rxclk_phase_ctrl #(.HOLD_MAX(HOLD_MAX)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_stb   (char_stb),
    .ref_tick   (ref_tick),
    .lock_ok    (lock_ok),
    .realign_req(realign_req),
    .is_comma   (is_comma),
    .half_ok    (half_ok),
    .full_ok    (full_ok),
    .cmd        (cmd)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    rxclk_lane_out #(.CHAR_W(CHAR_W), .IS_PH1(g == 1)) i_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (cmd.fire),
      .to_ph1 (cmd.to_ph1),
      .load   (cmd.load),
      .char_in(char_in),
      .level  (lane_level[g]),
      .rise   (lane_rise[g]),
      .data   (lane_data[g])
    );
  end

  assign rbc0   = lane_level[0];
  assign rbc1   = lane_level[1];
  assign rise0  = lane_rise[0];
  assign rise1  = lane_rise[1];
  assign rx_ph0 = lane_data[0];
  assign rx_ph1 = lane_data[1];

endmodule

// File: rtl/rxclk_dual_phase_sva.sv
module rxclk_dual_phase_sva #(
  parameter int CHAR_W = 10,
  parameter int HALF   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_ok,
  input logic              rbc0,
  input logic              rbc1,
  input logic              rise0,
  input logic              rise1,
  input logic [CHAR_W-1:0] rx_ph0,
  input logic [CHAR_W-1:0] rx_ph1
);
  localparam logic [15:0] GAP_SAT = 16'hFFFF;

  logic        prev0_q;
  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev0_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      prev0_q <= rbc0;
      if (rbc0 != prev0_q) begin
        gap_q <= 16'd1;
      end else if (gap_q != GAP_SAT) begin
        gap_q <= gap_q + 16'd1;
      end
    end
  end

  p_antiphase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rbc1 != rbc0);

  p_min_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rbc0 != prev0_q) |-> (gap_q >= 16'(HALF)));

  p_ref_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rbc0 != prev0_q) && !$past(lock_ok)) |-> (gap_q >= 16'(2 * HALF)));

  p_hold_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rbc0 == prev0_q) |-> ((rx_ph0 == $past(rx_ph0)) && (rx_ph1 == $past(rx_ph1))));

  p_rise_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise0 |-> (rbc0 && !prev0_q)) and (rise1 |-> (rbc1 && prev0_q)));

  p_no_load_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lock_ok) |-> ($stable(rx_ph0) && $stable(rx_ph1)));

endmodule

bind rxclk_dual_phase rxclk_dual_phase_sva #(.CHAR_W(CHAR_W), .HALF(HALF)) i_sva (
  .clk    (clk),
  .rst_n  (rst_n),
  .lock_ok(lock_ok),
  .rbc0   (rbc0),
  .rbc1   (rbc1),
  .rise0  (rise0),
  .rise1  (rise1),
  .rx_ph0 (rx_ph0),
  .rx_ph1 (rx_ph1)
);

// File: tb/test_rxclk_dual_phase.sv
module test_rxclk_dual_phase;
  localparam int CLK_PERIOD = 10;
  localparam int CHAR_W     = 10;
  localparam int HALF       = 10;
  localparam int HOLD_MAX   = 4;
  localparam int NVEC       = 8;
  localparam logic [CHAR_W-1:0] COMMA = 10'h0FC;
  localparam logic [CHAR_W-1:0] VEC [NVEC] = '{
    10'h155, 10'h2AA, 10'h0F0, 10'h30F, 10'h1C7, 10'h238, 10'h3FF, 10'h001
  };

  logic              clk;
  logic              rst_n;
  logic              char_stb;
  logic [CHAR_W-1:0] char_in;
  logic              realign_req;
  logic              lock_ok;
  logic              ref_tick;
  logic              rbc0;
  logic              rbc1;
  logic              rise0;
  logic              rise1;
  logic [CHAR_W-1:0] rx_ph0;
  logic [CHAR_W-1:0] rx_ph1;

  int n_tests;
  int n_fail;
  int gap_cnt;
  int last_gap;
  int min_gap;
  logic prev0;
  logic last_ph;

  rxclk_dual_phase #(.CHAR_W(CHAR_W), .HALF(HALF), .HOLD_MAX(HOLD_MAX)) i_rxclk_dual_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_stb   (char_stb),
    .char_in    (char_in),
    .realign_req(realign_req),
    .lock_ok    (lock_ok),
    .ref_tick   (ref_tick),
    .rbc0       (rbc0),
    .rbc1       (rbc1),
    .rise0      (rise0),
    .rise1      (rise1),
    .rx_ph0     (rx_ph0),
    .rx_ph1     (rx_ph1)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // Half-period monitor of rbc0, counted in whole bit clocks.
  always @(negedge clk) begin
    if (!rst_n) begin
      gap_cnt  = 0;
      last_gap = 0;
      min_gap  = 1000;
      prev0    = 1'b0;
    end else if (rbc0 !== prev0) begin
      last_gap = gap_cnt;
      if (gap_cnt < min_gap) min_gap = gap_cnt;
      gap_cnt = 1;
      prev0   = rbc0;
    end else begin
      gap_cnt = gap_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe one character; returns just after the falling edge that follows
  // the sampling rising edge, while the rise pulses are valid.
  task automatic send(input logic [CHAR_W-1:0] c, input logic rq);
    @(negedge clk);
    char_stb    = 1'b1;
    char_in     = c;
    realign_req = rq;
    @(negedge clk);
    char_stb    = 1'b0;
    realign_req = 1'b0;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    #1;
  endtask

  task automatic expect_rise(input logic ph1, input logic [CHAR_W-1:0] c, input string req);
    check((rise0 == !ph1) && (rise1 == ph1), req, {rise1, rise0}, ph1 ? 2 : 1);
    if (ph1) check(rx_ph1 == c, req, rx_ph1, c);
    else     check(rx_ph0 == c, req, rx_ph0, c);
    check(rbc1 == !rbc0, "R2 antiphase", rbc1, !rbc0);
    last_ph = ph1;
  endtask

  task automatic expect_none(input string req);
    check(!rise0 && !rise1, req, {rise1, rise0}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [CHAR_W-1:0] h0;
    logic [CHAR_W-1:0] h1;
    logic              lvl;
    logic              p0;
    n_tests     = 0;
    n_fail      = 0;
    rst_n       = 1'b0;
    char_stb    = 1'b0;
    char_in     = '0;
    realign_req = 1'b0;
    lock_ok     = 1'b0;
    ref_tick    = 1'b0;
    last_ph     = 1'b0;
    idle(3);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(rbc0 == 1'b0 && rbc1 == 1'b1, "R1 clock levels", {rbc1, rbc0}, 2);
    check(!rise0 && !rise1, "R1 rise strobes", {rise1, rise0}, 0);
    check(rx_ph0 == '0 && rx_ph1 == '0, "R1 characters", rx_ph0 | rx_ph1, 0);

    // R6: reference mode, ticks every HALF clocks, strobes ignored
    for (int i = 0; i < 8; i++) begin
      tick();
      if (i == 3) begin
        send(10'h3C3, 1'b0);
        idle(6);
      end else begin
        idle(8);
      end
    end
    check(last_gap == 2 * HALF, "R6 fallback half-period", last_gap, 2 * HALF);
    check(rx_ph0 == '0 && rx_ph1 == '0, "R6 no load in fallback", rx_ph0 | rx_ph1, 0);

    // R3/R4: locked stream from the vector table
    lock_ok = 1'b1;
    idle(12);
    p0 = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i], 1'b0);
      if (i == 0) p0 = rise1;
      expect_rise(p0 ^ logic'(i % 2), VEC[i], "R3 R4 locked stream");
      if (i > 0) check(last_gap == HALF, "R4 nominal half-period", last_gap, HALF);
      idle(8);
    end

    // R5: early strobe ignored, later one accepted
    idle(-8 + 2 + 8 - 8 > 0 ? 0 : 0);
    h0 = rx_ph0;
    h1 = rx_ph1;
    // last strobe was 10 cycles ago minus idle(8): redo spacing from scratch
    send(10'h0A5, 1'b0);
    expect_rise(!last_ph, 10'h0A5, "R5 reference edge");
    h0 = rx_ph0;
    h1 = rx_ph1;
    idle(2);
    send(10'h2C4, 1'b0);
    expect_none("R5 early strobe no edge");
    check(rx_ph0 == h0 && rx_ph1 == h1, "R5 early strobe data held", rx_ph0 ^ h0, 0);
    idle(4);
    send(10'h1D2, 1'b0);
    expect_rise(!last_ph, 10'h1D2, "R5 strobe after full half-period");

    // bring the due phase to rbc0
    if (last_ph == 1'b0) begin
      idle(8);
      send(10'h066, 1'b0);
      expect_rise(1'b1, 10'h066, "R4 alignment step");
    end

    // R7: realign waits for the rbc1 boundary, then hunts for a comma
    idle(8);
    send(10'h133, 1'b1);
    expect_rise(1'b0, 10'h133, "R7 rbc0 boundary served");
    idle(8);
    send(10'h155, 1'b0);
    expect_none("R7 non-comma discarded");
    check(rbc0 == 1'b1, "R7 rbc0 stretched high", rbc0, 1);
    idle(8);
    send(COMMA, 1'b0);
    expect_rise(1'b1, COMMA, "R7 comma on rbc1");
    check(last_gap == 2 * HALF, "R7 stretched half-period", last_gap, 2 * HALF);

    // R8/R9: near-miss is not a comma; hunt times out after HOLD_MAX
    idle(8);
    send(10'h111, 1'b1);
    expect_rise(1'b0, 10'h111, "R9 rbc0 boundary served");
    idle(8);
    send(10'h0FD, 1'b0);
    expect_none("R8 near-miss not a comma");
    idle(8);
    send(10'h122, 1'b0);
    expect_none("R9 hunt discard");
    idle(8);
    send(10'h144, 1'b0);
    expect_none("R9 hunt discard");
    idle(8);
    send(10'h188, 1'b0);
    expect_none("R9 hunt discard");
    idle(8);
    send(10'h199, 1'b0);
    expect_rise(1'b1, 10'h199, "R9 timeout takes character");
    check(last_gap == (HOLD_MAX + 1) * HALF, "R9 hunt half-period", last_gap, (HOLD_MAX + 1) * HALF);

    // R10: lock loss cancels a pending realign
    @(negedge clk);
    lock_ok     = 1'b0;
    realign_req = 1'b1;
    @(negedge clk);
    realign_req = 1'b0;
    idle(2);
    lock_ok = 1'b1;
    idle(10);
    send(10'h1E1, 1'b0);
    expect_rise(1'b0, 10'h1E1, "R10 rbc0 after relock");
    idle(8);
    send(10'h1E2, 1'b0);
    expect_rise(1'b1, 10'h1E2, "R10 rbc1 served, no hunt");

    // R11: change to reference mode keeps the long half-period
    lock_ok = 1'b0;
    lvl = rbc0;
    idle(10);
    tick();
    check(rbc0 == lvl, "R11 early tick ignored", rbc0, lvl);
    idle(8);
    tick();
    check(rbc0 == !lvl, "R11 tick after 2*HALF", rbc0, !lvl);

    // R5: global minimum half-period
    check(min_gap >= HALF, "R5 minimum half-period", min_gap, HALF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule